// File: doc/BRIEF.md
# Debug-Mode Entry Controller

This block decides, cycle by cycle, when a small in-order processor stops normal execution and enters debug mode, and when it returns. It sees an external halt request, the decoded breakpoint, debug-return and wait-for-interrupt instructions, retire and exception pulses, the current privilege level, and three control bits: single-step, breakpoint-to-debug in machine mode, and breakpoint-to-debug in user mode. From these it raises a one-cycle entry pulse with a cause code and a pipeline flush with a redirect address. It holds the saved return PC and the recorded cause.

While the core is in debug mode, the block masks interrupts and keeps the core from sleeping. A breakpoint restarts the debug code at its entry point. An exception kills the register write-back and sends the core to a debug exception address. A debug return sends the core back to the saved PC. With single-step armed on return, the block re-enters debug mode after exactly one instruction. A halt request wakes a core that is asleep after a wait-for-interrupt.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, debug mode, sleep, the saved PC and the cause code are all zero, and no flush, entry or interrupt-take is signalled while the inputs are idle.
- R2: A halt request outside debug mode gives, in the same cycle, an entry pulse and a flush that redirects to ENTRY_ADDR. In the next cycle debug mode is 1, the cause is 3 and the saved PC equals `pc_next_i`.
- R3: A breakpoint outside debug mode enters debug mode when the privilege is machine (`priv_i`=2'b11) and the machine enable is set, or when the privilege is user (2'b00) and the user enable is set. The cause is then 1 and the saved PC is `pc_cur_i`. In every other case `brk_exc_o` is raised and debug mode is not entered.
- R4: A debug return with single-step set arms stepping. The next retire or exception (not earlier idle cycles) then enters debug mode with cause 4 and saved PC `pc_next_i`.
- R5: Entry priority is breakpoint, then halt request, then step. A halt request that coincides with a pending step records cause 3. A breakpoint that coincides with a halt request records cause 1.
- R6: A wait-for-interrupt outside debug mode sets sleep in the next cycle. While the core is asleep, a pending interrupt is taken and clears sleep. A halt request instead enters debug mode and clears sleep.
- R7: In debug mode and in the cycle of entry, `irq_take_o` stays 0 whatever `irq_pending_i` does. A halt request in debug mode produces no entry pulse and leaves the saved PC and cause unchanged.
- R8: A breakpoint in debug mode flushes to ENTRY_ADDR without an entry pulse, stays in debug mode, and keeps the saved PC and cause.
- R9: A debug return outside debug mode raises `illegal_o`, produces no flush and changes no state.
- R10: An exception in debug mode raises `kill_wb_o` and flushes to EXC_ADDR. The block stays in debug mode and keeps the saved PC.
- R11: A wait-for-interrupt in debug mode does not set sleep and does not flush.
- R12: A debug return in debug mode flushes with redirect equal to the saved PC, and debug mode reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | External halt request |
| ebreak_i | input | 1 | Breakpoint instruction in execute |
| dret_i | input | 1 | Debug-return instruction in execute |
| wfi_i | input | 1 | Wait-for-interrupt instruction in execute |
| retire_i | input | 1 | An instruction retired this cycle |
| exc_i | input | 1 | An exception is raised this cycle |
| irq_pending_i | input | 1 | An enabled interrupt is pending |
| priv_i | input | 2 | Privilege level: 2'b11 machine, 2'b00 user |
| step_en_i | input | 1 | Single-step control bit |
| ebrk_m_en_i | input | 1 | Breakpoint enters debug in machine mode |
| ebrk_u_en_i | input | 1 | Breakpoint enters debug in user mode |
| pc_cur_i | input | PC_W | PC of the instruction in execute |
| pc_next_i | input | PC_W | PC of the next instruction to run |
| debug_mode_o | output | 1 | Core is in debug mode |
| enter_o | output | 1 | Entry pulse for this cycle |
| cause_o | output | 3 | Recorded entry cause (1 breakpoint, 3 halt request, 4 step) |
| dpc_o | output | PC_W | Saved return PC |
| irq_take_o | output | 1 | Pending interrupt may be taken |
| flush_o | output | 1 | Flush the pipeline and redirect |
| redirect_pc_o | output | PC_W | Target of the flush |
| brk_exc_o | output | 1 | Breakpoint becomes an ordinary exception |
| illegal_o | output | 1 | Debug return is an illegal instruction |
| kill_wb_o | output | 1 | Suppress register write-back |
| sleep_o | output | 1 | Core is asleep after wait-for-interrupt |

## Verification
The bench sweeps every combination of privilege and the two breakpoint enables. A design that routed by the wrong enable would enter debug mode on a user breakpoint with only the machine bit set, or would miss an entry. Single-step is driven through idle cycles before the retire: a design that re-entered on arming alone would pulse too early, and one that ignored the arm would never return with cause 4. Simultaneous halt request, pending step and breakpoint expose a wrong priority through the recorded cause. Interrupts, halt requests, wait-for-interrupt and exceptions are applied inside debug mode: a leaky mask would show `irq_take_o`, and a wrong state update would move the saved PC or let the core fall asleep.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
   // Cause codes follow the standard debug encoding; the core's CSR file decodes them.
   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_EBREAK  = 3'd1,
      CAUSE_HALTREQ = 3'd3,
      CAUSE_STEP    = 3'd4
   } dbg_cause_e;

   localparam logic [1:0] PRIV_MACHINE = 2'b11;
   localparam logic [1:0] PRIV_USER    = 2'b00;
endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
   import dbg_ctrl_pkg::*;
#(
   parameter int unsigned      PC_W       = 32,
   parameter logic [PC_W-1:0] ENTRY_ADDR = '0,
   parameter logic [PC_W-1:0] EXC_ADDR   = '0
) (
   input  logic            debug_q,
   input  logic            sleep_q,
   input  logic            step_armed_q,
   input  logic [PC_W-1:0] dpc_q,
   input  logic            ext_req_i,
   input  logic            ebreak_i,
   input  logic            dret_i,
   input  logic            wfi_i,
   input  logic            retire_i,
   input  logic            exc_i,
   input  logic            irq_pending_i,
   input  logic [1:0]      priv_i,
   input  logic            ebrk_m_en_i,
   input  logic            ebrk_u_en_i,
   input  logic [PC_W-1:0] pc_cur_i,
   input  logic [PC_W-1:0] pc_next_i,
   output logic            enter_o,
   output dbg_cause_e      cause_o,
   output logic [PC_W-1:0] entry_pc_o,
   output logic            ret_o,
   output logic            brk_exc_o,
   output logic            illegal_o,
   output logic            kill_wb_o,
   output logic            flush_o,
   output logic [PC_W-1:0] redirect_pc_o,
   output logic            go_sleep_o,
   output logic            wake_o,
   output logic            irq_take_o
);
   logic outside, brk_routed, brk_go, req_go, step_go;
   logic in_exc, in_rebrk;

   always_comb begin
      outside    = !debug_q;
      brk_routed = ((priv_i == PRIV_MACHINE) && ebrk_m_en_i) ||
                   ((priv_i == PRIV_USER)    && ebrk_u_en_i);
      brk_go     = outside && ebreak_i && brk_routed;
      req_go     = outside && ext_req_i;
      step_go    = outside && step_armed_q && (retire_i || exc_i);
      enter_o    = brk_go || req_go || step_go;

      // Priority: breakpoint, then halt request, then step.
      if (brk_go) begin
         cause_o    = CAUSE_EBREAK;
         entry_pc_o = pc_cur_i;
      end else if (req_go) begin
         cause_o    = CAUSE_HALTREQ;
         entry_pc_o = pc_next_i;
      end else begin
         cause_o    = CAUSE_STEP;
         entry_pc_o = pc_next_i;
      end

      brk_exc_o  = outside && ebreak_i && !brk_routed && !enter_o;
      illegal_o  = outside && dret_i && !enter_o;

      in_exc     = debug_q && exc_i;
      ret_o      = debug_q && dret_i && !exc_i;
      in_rebrk   = debug_q && ebreak_i && !exc_i && !dret_i;
      kill_wb_o  = in_exc;

      flush_o    = enter_o || in_exc || ret_o || in_rebrk;
      if (enter_o || in_rebrk) redirect_pc_o = ENTRY_ADDR;
      else if (in_exc)         redirect_pc_o = EXC_ADDR;
      else if (ret_o)          redirect_pc_o = dpc_q;
      else                     redirect_pc_o = '0;

      irq_take_o = outside && irq_pending_i && !enter_o;
      go_sleep_o = outside && wfi_i && !enter_o;
      wake_o     = sleep_q && (enter_o || irq_take_o);
   end
endmodule

// File: rtl/dbg_mode_regs.sv
module dbg_mode_regs
   import dbg_ctrl_pkg::*;
#(
   parameter int unsigned PC_W         = 32,
   parameter bit          STEP_SUPPORT = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            enter_i,
   input  dbg_cause_e      cause_i,
   input  logic [PC_W-1:0] entry_pc_i,
   input  logic            ret_i,
   input  logic            step_en_i,
   input  logic            go_sleep_i,
   input  logic            wake_i,
   output logic            debug_q,
   output logic            sleep_q,
   output logic            step_armed_q,
   output logic [PC_W-1:0] dpc_q,
   output dbg_cause_e      cause_q
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         debug_q <= 1'b0;
         dpc_q   <= '0;
         cause_q <= CAUSE_NONE;
      end else if (enter_i) begin
         debug_q <= 1'b1;
         dpc_q   <= entry_pc_i;
         cause_q <= cause_i;
      end else if (ret_i) begin
         debug_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sleep_q <= 1'b0;
      else if (wake_i)     sleep_q <= 1'b0;
      else if (go_sleep_i) sleep_q <= 1'b1;
   end

   generate
      if (STEP_SUPPORT) begin : g_step
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      step_armed_q <= 1'b0;
            else if (enter_i) step_armed_q <= 1'b0;
            else if (ret_i)   step_armed_q <= step_en_i;
         end
      end else begin : g_no_step
         assign step_armed_q = 1'b0;
      end
   endgenerate

   // R2: an entry pulse lands the core in debug mode with the captured PC.
   assert_enter_sets_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enter_i |=> debug_q && (dpc_q == $past(entry_pc_i)));
   // R12: a debug return leaves debug mode on the next cycle.
   assert_ret_leaves_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i |=> !debug_q);
   // R6: the core never sleeps while in debug mode.
   assert_sleep_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_q |-> !debug_q);
   // R8: saved PC and cause hold throughout debug mode.
   assert_dpc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      debug_q |=> $stable(dpc_q) && $stable(cause_q));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
   import dbg_ctrl_pkg::*;
#(
   parameter int unsigned      PC_W         = 32,
   parameter logic [PC_W-1:0] ENTRY_ADDR   = 'h800,
   parameter logic [PC_W-1:0] EXC_ADDR     = 'h808,
   parameter bit               STEP_SUPPORT = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            ext_req_i,
   input  logic            ebreak_i,
   input  logic            dret_i,
   input  logic            wfi_i,
   input  logic            retire_i,
   input  logic            exc_i,
   input  logic            irq_pending_i,
   input  logic [1:0]      priv_i,
   input  logic            step_en_i,
   input  logic            ebrk_m_en_i,
   input  logic            ebrk_u_en_i,
   input  logic [PC_W-1:0] pc_cur_i,
   input  logic [PC_W-1:0] pc_next_i,
   output logic            debug_mode_o,
   output logic            enter_o,
   output logic [2:0]      cause_o,
   output logic [PC_W-1:0] dpc_o,
   output logic            irq_take_o,
   output logic            flush_o,
   output logic [PC_W-1:0] redirect_pc_o,
   output logic            brk_exc_o,
   output logic            illegal_o,
   output logic            kill_wb_o,
   output logic            sleep_o
);
   localparam int unsigned ALIGN_MASK_W = 1;

   generate
      if (PC_W < 8) begin : g_bad_width
         $error("dbg_mode_ctrl: PC_W must be at least 8");
      end
      if ((ENTRY_ADDR[ALIGN_MASK_W-1:0] != '0) || (EXC_ADDR[ALIGN_MASK_W-1:0] != '0)) begin : g_bad_align
         $error("dbg_mode_ctrl: debug addresses must be halfword aligned");
      end
   endgenerate

   logic            debug_q, sleep_q, step_armed_q;
   logic [PC_W-1:0] dpc_q, entry_pc;
   dbg_cause_e      cause_q, cause_new;
   logic            ret, go_sleep, wake;

   dbg_entry_arb #(.PC_W(PC_W), .ENTRY_ADDR(ENTRY_ADDR), .EXC_ADDR(EXC_ADDR)) arb_i (
      .debug_q       (debug_q),
      .sleep_q       (sleep_q),
      .step_armed_q  (step_armed_q),
      .dpc_q         (dpc_q),
      .ext_req_i     (ext_req_i),
      .ebreak_i      (ebreak_i),
      .dret_i        (dret_i),
      .wfi_i         (wfi_i),
      .retire_i      (retire_i),
      .exc_i         (exc_i),
      .irq_pending_i (irq_pending_i),
      .priv_i        (priv_i),
      .ebrk_m_en_i   (ebrk_m_en_i),
      .ebrk_u_en_i   (ebrk_u_en_i),
      .pc_cur_i      (pc_cur_i),
      .pc_next_i     (pc_next_i),
      .enter_o       (enter_o),
      .cause_o       (cause_new),
      .entry_pc_o    (entry_pc),
      .ret_o         (ret),
      .brk_exc_o     (brk_exc_o),
      .illegal_o     (illegal_o),
      .kill_wb_o     (kill_wb_o),
      .flush_o       (flush_o),
      .redirect_pc_o (redirect_pc_o),
      .go_sleep_o    (go_sleep),
      .wake_o        (wake),
      .irq_take_o    (irq_take_o)
   );

   dbg_mode_regs #(.PC_W(PC_W), .STEP_SUPPORT(STEP_SUPPORT)) regs_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .enter_i      (enter_o),
      .cause_i      (cause_new),
      .entry_pc_i   (entry_pc),
      .ret_i        (ret),
      .step_en_i    (step_en_i),
      .go_sleep_i   (go_sleep),
      .wake_i       (wake),
      .debug_q      (debug_q),
      .sleep_q      (sleep_q),
      .step_armed_q (step_armed_q),
      .dpc_q        (dpc_q),
      .cause_q      (cause_q)
   );

   assign debug_mode_o = debug_q;
   assign cause_o      = cause_q;
   assign dpc_o        = dpc_q;
   assign sleep_o      = sleep_q;

   // R7: interrupts are never taken while debug code runs.
   assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      debug_mode_o |-> !irq_take_o);
   // R9: a stray debug return outside debug mode changes nothing.
   assert_dret_inert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!debug_mode_o && dret_i && !enter_o) |=> !debug_mode_o && $stable(dpc_o));
endmodule

// File: tb/dbg_mode_ctrl_tb_top.sv
module dbg_mode_ctrl_tb_top;
   localparam int unsigned PC_W  = 32;
   localparam logic [31:0] ENTRY = 32'h800;
   localparam logic [31:0] EXCA  = 32'h808;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_req, ebreak, dret, wfi, retire, exc, irq_pend;
   logic [1:0] priv;
   logic step_en, m_en, u_en;
   logic [31:0] pc_cur, pc_next;
   logic debug_mode, enter, flush, brk_exc, illegal, kill_wb, sleep, irq_take;
   logic [2:0] cause;
   logic [31:0] dpc, redir;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dbg_mode_ctrl #(.PC_W(PC_W), .ENTRY_ADDR(ENTRY), .EXC_ADDR(EXCA)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .ebreak_i(ebreak), .dret_i(dret),
      .wfi_i(wfi), .retire_i(retire), .exc_i(exc), .irq_pending_i(irq_pend), .priv_i(priv),
      .step_en_i(step_en), .ebrk_m_en_i(m_en), .ebrk_u_en_i(u_en), .pc_cur_i(pc_cur),
      .pc_next_i(pc_next), .debug_mode_o(debug_mode), .enter_o(enter), .cause_o(cause),
      .dpc_o(dpc), .irq_take_o(irq_take), .flush_o(flush), .redirect_pc_o(redir),
      .brk_exc_o(brk_exc), .illegal_o(illegal), .kill_wb_o(kill_wb), .sleep_o(sleep)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic clr();
      ext_req = 0; ebreak = 0; dret = 0; wfi = 0; retire = 0; exc = 0; irq_pend = 0;
      step_en = 0;
   endtask

   // Inputs change 1 ns after a rising edge; combinational outputs are read 1 ns later.
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic halt_in(input logic [31:0] nxt);
      clr(); ext_req = 1; pc_next = nxt; tick(); clr();
   endtask

   task automatic leave(input logic stp);
      clr(); dret = 1; step_en = stp; tick(); clr();
   endtask

   initial begin
      clr(); priv = 2'b11; m_en = 0; u_en = 0; pc_cur = 0; pc_next = 0;
      tick(); tick(); rst_n = 1; tick();
      #1;
      chk(debug_mode, 0, "R1 debug after reset");
      chk(sleep, 0, "R1 sleep after reset");
      chk(cause, 0, "R1 cause after reset");
      chk(dpc, 0, "R1 dpc after reset");
      chk(flush, 0, "R1 flush idle");
      chk(enter, 0, "R1 enter idle");
      chk(irq_take, 0, "R1 irq_take idle");

      // R2 halt request, with R7 entry-cycle masking
      ext_req = 1; pc_next = 32'h100; irq_pend = 1; #1;
      chk(enter, 1, "R2 enter pulse");
      chk(flush, 1, "R2 flush");
      chk(redir, ENTRY, "R2 redirect");
      chk(irq_take, 0, "R7 irq on entry cycle");
      tick(); clr();
      chk(debug_mode, 1, "R2 debug mode");
      chk(cause, 3, "R2 cause");
      chk(dpc, 32'h100, "R2 dpc");

      // R7 inside debug mode
      irq_pend = 1; ext_req = 1; pc_next = 32'h900; #1;
      chk(irq_take, 0, "R7 irq in debug");
      chk(enter, 0, "R7 no re-entry on request");
      tick(); clr();
      chk(dpc, 32'h100, "R7 dpc kept");
      chk(cause, 3, "R7 cause kept");

      // R11 wfi in debug
      wfi = 1; #1;
      chk(flush, 0, "R11 no flush");
      tick(); clr();
      chk(sleep, 0, "R11 no sleep");

      // R10 exception in debug
      exc = 1; #1;
      chk(kill_wb, 1, "R10 kill write-back");
      chk(flush, 1, "R10 flush");
      chk(redir, EXCA, "R10 redirect");
      tick(); clr();
      chk(debug_mode, 1, "R10 stays in debug");
      chk(dpc, 32'h100, "R10 dpc kept");

      // R8 ebreak in debug
      ebreak = 1; pc_cur = 32'h804; #1;
      chk(flush, 1, "R8 flush");
      chk(redir, ENTRY, "R8 redirect");
      chk(enter, 0, "R8 no entry pulse");
      tick(); clr();
      chk(debug_mode, 1, "R8 stays in debug");
      chk(dpc, 32'h100, "R8 dpc kept");
      chk(cause, 3, "R8 cause kept");

      // R12 dret
      dret = 1; #1;
      chk(flush, 1, "R12 flush");
      chk(redir, 32'h100, "R12 redirect to dpc");
      tick(); clr();
      chk(debug_mode, 0, "R12 left debug");

      // R9 dret outside debug
      dret = 1; #1;
      chk(illegal, 1, "R9 illegal");
      chk(flush, 0, "R9 no flush");
      tick(); clr();
      chk(debug_mode, 0, "R9 still normal");
      chk(dpc, 32'h100, "R9 dpc unchanged");

      // R3 sweep over privilege and both enables
      for (int p = 0; p < 2; p++) begin
         for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 2; u++) begin
               automatic logic [31:0] a = 32'h200 + 32'(p * 16 + m * 8 + u * 4);
               automatic logic expect_in = (p == 1) ? (m == 1) : (u == 1);
               priv = (p == 1) ? 2'b11 : 2'b00; m_en = m[0]; u_en = u[0];
               ebreak = 1; pc_cur = a; pc_next = a + 4; #1;
               chk(enter, expect_in, "R3 enter");
               chk(brk_exc, !expect_in, "R3 breakpoint exception");
               tick(); clr();
               chk(debug_mode, expect_in, "R3 mode");
               if (expect_in) begin
                  chk(cause, 1, "R3 cause");
                  chk(dpc, a, "R3 dpc");
                  leave(0);
               end
            end
         end
      end
      priv = 2'b11; m_en = 0; u_en = 0;

      // R4 single step
      halt_in(32'h300);
      leave(1);
      chk(debug_mode, 0, "R4 left debug");
      #1; chk(enter, 0, "R4 no entry before retire");
      tick(); tick();
      chk(debug_mode, 0, "R4 idle cycles stay normal");
      retire = 1; pc_next = 32'h344; #1;
      chk(enter, 1, "R4 entry on retire");
      tick(); clr();
      chk(cause, 4, "R4 cause");
      chk(dpc, 32'h344, "R4 dpc");
      leave(0);
      retire = 1; pc_next = 32'h348; #1;
      chk(enter, 0, "R4 disarmed after plain return");
      tick(); clr();

      // R5 priority
      halt_in(32'h380);
      leave(1);
      retire = 1; ext_req = 1; pc_next = 32'h400; tick(); clr();
      chk(cause, 3, "R5 request over step");
      chk(dpc, 32'h400, "R5 dpc request");
      leave(0);
      m_en = 1; ebreak = 1; ext_req = 1; pc_cur = 32'h420; pc_next = 32'h424; tick(); clr();
      chk(cause, 1, "R5 breakpoint over request");
      chk(dpc, 32'h420, "R5 dpc breakpoint");
      leave(0); m_en = 0;

      // R6 sleep and wake
      wfi = 1; tick(); clr();
      chk(sleep, 1, "R6 asleep");
      irq_pend = 1; #1;
      chk(irq_take, 1, "R6 irq taken when asleep");
      tick(); clr();
      chk(sleep, 0, "R6 woken by irq");
      wfi = 1; tick(); clr();
      chk(sleep, 1, "R6 asleep again");
      ext_req = 1; pc_next = 32'h500; #1;
      chk(enter, 1, "R6 request enters from sleep");
      tick(); clr();
      chk(sleep, 0, "R6 woken by request");
      chk(debug_mode, 1, "R6 in debug");
      chk(cause, 3, "R6 cause");
      leave(0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule